// File: doc/BRIEF.md
# Counter-Rotating Rotor Phase Generator

This block produces angle setpoints for the four eccentric masses of a force generator. The masses form two pairs, and the two masses of each pair spin about a shared axis in opposite directions. A 32-bit phase accumulator advances a base angle by a frequency tuning word on every sample tick. The first pair is placed at the base angle plus a split angle phi. The second pair is placed at the base angle minus phi. The counter-rotating mass of each pair gets the mirrored (negated) angle. The summed peak force therefore follows cos(phi). An 8-bit force ratio command is turned into phi through an inverse-cosine lookup. Phi is moved toward that lookup value by at most one step per tick, so that a change in force demand does not cause a jump.

The host writes a tuning word and a ratio together under a valid strobe. The tuning word for the supported 14 to 24 Hz range is computed from the tick rate outside this block. The block also compares a measured rotor speed against the commanded one, using a ±2.5% window. Speed samples taken just after a frequency change are ignored for a settable number of ticks.

Top module: `rotor_phase_gen`

## Requirements
- R1: After reset, all four angle outputs and the fault flag read zero until the first sample tick. The held tuning word and ratio are zero, and phi starts at a quarter turn (16384).
- R2: The command inputs `cmd_ftw` and `cmd_ratio` are taken in only on a clock edge where `cmd_valid` is high. Values present without the strobe have no effect on any output.
- R3: On each tick the 32-bit accumulator adds the tuning word that was held before that edge. The base angle is accumulator bits [31:16], where 65536 equals one turn.
- R4: Pair A outputs are `ang_a1` = base + phi and `ang_a2` = −(base + phi), both modulo 2^16. They are registered on the tick.
- R5: Pair B outputs are `ang_b1` = base − phi and `ang_b2` = −(base − phi), both modulo 2^16. They are registered on the tick.
- R6: The phi target for ratio r is round(acos(r/255)/(2π)·65536). Ratio 255 gives 0 (full force) and ratio 0 gives 16384 (zero net force). Phi settles exactly on this target.
- R7: On each tick phi moves one LSB toward the target of the ratio held before that edge, or stays put once it has reached the target. Phi never changes between ticks.
- R8: On clock edges without a tick, all four angle outputs and the fault flag keep their values.
- R9: On a tick outside the blanking period, the fault flag is set to 1 exactly when |speed_meas − ftw| > (ftw·205) >> 13. Here `ftw` is the held tuning word, and the measured speed is given in the same tuning-word units. Otherwise the flag is set to 0.
- R10: A strobed command whose tuning word differs from the held one loads `holdoff_ticks` into a blanking counter. The fault flag is forced to 0 on the tick at that edge and on the next `holdoff_ticks` ticks. A strobed command that repeats the held tuning word does not restart blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample tick enable |
| cmd_valid | input | 1 | Strobe to latch the command fields |
| cmd_ftw | input | 32 | Frequency tuning word (phase increment per tick) |
| cmd_ratio | input | 8 | Force ratio, 0 = none, 255 = full |
| holdoff_ticks | input | 16 | Number of ticks the speed check is ignored after a frequency change |
| speed_meas | input | 32 | Measured rotor speed in tuning-word units |
| ang_a1 | output | 16 | Pair A, forward mass angle |
| ang_a2 | output | 16 | Pair A, counter-rotating mass angle |
| ang_b1 | output | 16 | Pair B, forward mass angle |
| ang_b2 | output | 16 | Pair B, counter-rotating mass angle |
| ripple_fault | output | 1 | Speed outside the ripple window |

## Verification
The hardest state to reach is phi settling at the end of a long slew. Phi crawls one LSB per tick, so a move from a quarter turn to zero takes more than sixteen thousand ticks. The stimulus holds the tick high across that whole span, and the scoreboard compares every intermediate step before the final target value is checked. The fault window edge is reached by driving the measured speed exactly at, and one unit past, the computed tolerance. This happens just after the blanking count of a frequency change has run out.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    // Ripple tolerance as a fixed-point fraction: 205 / 8192 ~= 2.5 %
    localparam int unsigned TOL_NUM = 205;
    localparam int unsigned TOL_SH  = 13;

    // Split angle for a ratio step, in units of 2^aw per turn.
    function automatic int unsigned split_angle(input int unsigned r,
                                                input int unsigned rmax,
                                                input int unsigned aw);
        real turn_frac;
        turn_frac = $acos(real'(r) / real'(rmax)) / (2.0 * 3.14159265358979);
        return $rtoi(turn_frac * (2.0 ** aw) + 0.5);
    endfunction

endpackage

// File: rtl/rpg_phi_slew.sv
module rpg_phi_slew #(
    parameter int unsigned ANG_W = 16,
    parameter int unsigned R_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [R_W-1:0]   ratio,
    output logic [ANG_W-1:0] phi_next,
    output logic [ANG_W-1:0] phi_now
);
    import rpg_pkg::*;

    localparam int unsigned RN      = 1 << R_W;
    localparam logic [ANG_W-1:0] QUARTER = ANG_W'(1) << (ANG_W - 2);

    typedef struct packed {
        logic [ANG_W-1:0] phi;
    } slew_t;

    logic [ANG_W-1:0] rom [RN];
    slew_t s_d, s_q;
    logic [ANG_W-1:0] target;

    for (genvar i = 0; i < RN; i++) begin : g_rom
        assign rom[i] = ANG_W'(split_angle(i, RN - 1, ANG_W));
    end

    assign target = rom[ratio];

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (s_q.phi < target)
                s_d.phi = s_q.phi + ANG_W'(1);
            else if (s_q.phi > target)
                s_d.phi = s_q.phi - ANG_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '{phi: QUARTER};
        else
            s_q <= s_d;
    end

    assign phi_next = s_d.phi;
    assign phi_now  = s_q.phi;
endmodule

// File: rtl/rpg_ripple_mon.sv
module rpg_ripple_mon #(
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              freq_change,
    input  logic [ACC_W-1:0]  ftw,
    input  logic [ACC_W-1:0]  speed_meas,
    input  logic [HOLD_W-1:0] holdoff_ticks,
    output logic              fault,
    output logic              blanking
);
    import rpg_pkg::*;

    localparam int unsigned MW = ACC_W + $clog2(TOL_NUM + 1);

    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
        logic              flt;
    } mon_t;

    mon_t s_d, s_q;
    logic [MW-1:0]    prod;
    logic [MW-1:0]    window;
    logic [ACC_W-1:0] dev;
    logic             outside;

    always_comb begin
        prod    = MW'(ftw) * MW'(TOL_NUM);
        window  = prod >> TOL_SH;
        dev     = (speed_meas > ftw) ? (speed_meas - ftw) : (ftw - speed_meas);
        outside = MW'(dev) > window;

        s_d = s_q;
        if (tick)
            s_d.flt = (freq_change || s_q.cnt != '0) ? 1'b0 : outside;
        if (freq_change)
            s_d.cnt = holdoff_ticks;
        else if (tick && s_q.cnt != '0)
            s_d.cnt = s_q.cnt - HOLD_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign fault    = s_q.flt;
    assign blanking = s_q.cnt != '0;
endmodule

// File: rtl/rotor_phase_gen.sv
module rotor_phase_gen #(
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned ANG_W  = 16,
    parameter int unsigned R_W    = 8,
    parameter int unsigned HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic [ACC_W-1:0]  cmd_ftw,
    input  logic [R_W-1:0]    cmd_ratio,
    input  logic [HOLD_W-1:0] holdoff_ticks,
    input  logic [ACC_W-1:0]  speed_meas,
    output logic [ANG_W-1:0]  ang_a1,
    output logic [ANG_W-1:0]  ang_a2,
    output logic [ANG_W-1:0]  ang_b1,
    output logic [ANG_W-1:0]  ang_b2,
    output logic              ripple_fault
);
    localparam int unsigned BASE_LSB = ACC_W - ANG_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] ftw;
        logic [R_W-1:0]   ratio;
        logic [ANG_W-1:0] a1;
        logic [ANG_W-1:0] a2;
        logic [ANG_W-1:0] b1;
        logic [ANG_W-1:0] b2;
    } top_t;

    top_t s_d, s_q;
    logic [ANG_W-1:0] phi_next;
    logic [ANG_W-1:0] phi_now;
    logic [ANG_W-1:0] base;
    logic [ANG_W-1:0] lead;
    logic [ANG_W-1:0] lag;
    logic             freq_change;
    logic             blanking;

    rpg_phi_slew #(.ANG_W(ANG_W), .R_W(R_W)) u_slew (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ratio    (s_q.ratio),
        .phi_next (phi_next),
        .phi_now  (phi_now)
    );

    rpg_ripple_mon #(.ACC_W(ACC_W), .HOLD_W(HOLD_W)) u_mon (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .freq_change   (freq_change),
        .ftw           (s_q.ftw),
        .speed_meas    (speed_meas),
        .holdoff_ticks (holdoff_ticks),
        .fault         (ripple_fault),
        .blanking      (blanking)
    );

    assign freq_change = cmd_valid && (cmd_ftw != s_q.ftw);

    always_comb begin
        s_d = s_q;
        if (cmd_valid) begin
            s_d.ftw   = cmd_ftw;
            s_d.ratio = cmd_ratio;
        end
        if (tick)
            s_d.acc = s_q.acc + s_q.ftw;
        base = s_d.acc[ACC_W-1:BASE_LSB];
        lead = base + phi_next;
        lag  = base - phi_next;
        if (tick) begin
            s_d.a1 = lead;
            s_d.a2 = ANG_W'(0) - lead;
            s_d.b1 = lag;
            s_d.b2 = ANG_W'(0) - lag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign ang_a1 = s_q.a1;
    assign ang_a2 = s_q.a2;
    assign ang_b1 = s_q.b1;
    assign ang_b2 = s_q.b2;
endmodule

// File: rtl/rotor_phase_gen_chk.sv
module rotor_phase_gen_chk #(
    parameter int unsigned ANG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             blanking,
    input logic [ANG_W-1:0] ang_a1,
    input logic [ANG_W-1:0] ang_a2,
    input logic [ANG_W-1:0] ang_b1,
    input logic [ANG_W-1:0] ang_b2,
    input logic             ripple_fault
);
    localparam logic [ANG_W-1:0] HALF = ANG_W'(1) << (ANG_W - 1);

    logic             seen_q;
    logic [ANG_W-1:0] spread;

    assign spread = ang_a1 - ang_b1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else if (tick)
            seen_q <= 1'b1;
    end

    // R1: quiet outputs until the first tick
    a_r1_quiet_until_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (ang_a1 == '0 && ang_a2 == '0 && ang_b1 == '0 &&
                     ang_b2 == '0 && !ripple_fault));

    // R6: pair spread (twice phi) stays within half a turn
    a_r6_spread_range: assert property (@(posedge clk) disable iff (!rst_n)
        spread <= HALF);

    // R7: the spread moves by at most two LSBs per tick
    a_r7_slew_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen_q) |=> (ANG_W'(spread - $past(spread)) == ANG_W'(0) ||
                              ANG_W'(spread - $past(spread)) == ANG_W'(2) ||
                              ANG_W'(spread - $past(spread)) == ANG_W'(-2)));

    // R8: outputs hold without a tick
    a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(ang_a1) && $stable(ang_a2) && $stable(ang_b1) &&
                   $stable(ang_b2) && $stable(ripple_fault)));

    // R10: no fault on a tick taken during blanking
    a_r10_blank_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && blanking) |=> !ripple_fault);
endmodule

bind rotor_phase_gen rotor_phase_gen_chk #(.ANG_W(ANG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .blanking     (blanking),
    .ang_a1       (ang_a1),
    .ang_a2       (ang_a2),
    .ang_b1       (ang_b1),
    .ang_b2       (ang_b2),
    .ripple_fault (ripple_fault)
);

// File: tb/sim_rotor_phase_gen.sv
`timescale 1ns/1ps
module sim_rotor_phase_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_ftw = '0;
    logic [7:0]  cmd_ratio = '0;
    logic [15:0] holdoff_ticks = 16'd3;
    logic [31:0] speed_meas = '0;
    logic [15:0] ang_a1, ang_a2, ang_b1, ang_b2;
    logic        ripple_fault;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rotor_phase_gen u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_ftw(cmd_ftw), .cmd_ratio(cmd_ratio), .holdoff_ticks(holdoff_ticks),
        .speed_meas(speed_meas), .ang_a1(ang_a1), .ang_a2(ang_a2),
        .ang_b1(ang_b1), .ang_b2(ang_b2), .ripple_fault(ripple_fault)
    );

    typedef struct {
        logic [15:0] a1, a2, b1, b2;
        logic        f;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // reference state
    logic [31:0] m_acc = '0, m_ftw = '0;
    logic [7:0]  m_r = '0;
    int          m_phi = 16384;
    int          m_cnt = 0;
    logic [15:0] m_a1 = '0, m_a2 = '0, m_b1 = '0, m_b2 = '0;
    logic        m_f = 1'b0;

    function automatic int split_ref(input int r);
        real th;
        th = $acos(real'(r) / 255.0);
        return $rtoi(th / (2.0 * 3.14159265358979) * 65536.0 + 0.5);
    endfunction

    function automatic logic over_window(input logic [31:0] f, input logic [31:0] s);
        longint unsigned w, d;
        w = (longint'(f) * 205) >> 13;
        d = (s > f) ? longint'(s - f) : longint'(f - s);
        return d > w;
    endfunction

    task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle and pushes the expected registered result
    task automatic drive(input logic t, input logic v, input logic [31:0] f,
                         input logic [7:0] r, input logic [31:0] sm, input string tag);
        logic chg;
        int tgt;
        logic [15:0] base;
        exp_t e;
        @(negedge clk);
        tick = t; cmd_valid = v; cmd_ftw = f; cmd_ratio = r; speed_meas = sm;
        chg = v && (f != m_ftw);
        if (t) begin
            m_f = (chg || m_cnt != 0) ? 1'b0 : over_window(m_ftw, sm);
            tgt = split_ref(m_r);
            if (m_phi < tgt) m_phi++;
            else if (m_phi > tgt) m_phi--;
            m_acc = m_acc + m_ftw;
            base = m_acc[31:16];
            m_a1 = base + 16'(m_phi);
            m_a2 = 16'd0 - m_a1;
            m_b1 = base - 16'(m_phi);
            m_b2 = 16'd0 - m_b1;
        end
        if (chg) m_cnt = int'(holdoff_ticks);
        else if (t && m_cnt > 0) m_cnt--;
        if (v) begin m_ftw = f; m_r = r; end
        e.a1 = m_a1; e.a2 = m_a2; e.b1 = m_b1; e.b2 = m_b2; e.f = m_f; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {ang_a1, ang_a2, ang_b1, ang_b2, ripple_fault},
                      {e.a1, e.a2, e.b1, e.b2, e.f});
            end
        end
    end

    initial begin
        #1_500_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] f2, w2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports
        @(negedge clk);
        check("R1", {ang_a1, ang_a2, ang_b1, ang_b2, ripple_fault}, 65'd0);
        repeat (3) drive(0, 0, 32'd0, 8'd0, 32'd0, "R1");
        // R4 R5: first ticks, phi at a quarter turn, base zero
        repeat (2) drive(1, 0, 32'd0, 8'd0, 32'd0, "R4");
        // R2: command without strobe is ignored
        repeat (4) drive(1, 0, 32'hDEAD_BEEF, 8'd255, 32'd0, "R2");
        // R3: latch a tuning word, then accumulate
        drive(0, 1, 32'h0800_0000, 8'd0, 32'h0800_0000, "R2");
        repeat (20) drive(1, 0, 32'h0, 8'd0, 32'h0800_0000, "R3");
        // R8: no tick, outputs hold
        repeat (5) drive(0, 0, 32'h1234_0000, 8'd77, 32'h0, "R8");
        // R7 then R6: slew to full force, then to mid ratio
        drive(1, 1, 32'h0123_4567, 8'd255, 32'h0123_4567, "R7");
        repeat (16500) drive(1, 0, 32'h0, 8'd0, 32'h0123_4567, "R7");
        drive(1, 1, 32'h0123_4567, 8'd128, 32'h0123_4567, "R6");
        repeat (11000) drive(1, 0, 32'h0, 8'd0, 32'h0123_4567, "R6");
        drive(1, 1, 32'h0123_4567, 8'd200, 32'h0123_4567, "R7");
        repeat (400) drive(1, 0, 32'h0, 8'd0, 32'h0123_4567, "R7");
        // R10: frequency change with a bad speed: blanking then fault
        f2 = 32'h0100_0000;
        w2 = 32'((longint'(f2) * 205) >> 13);
        drive(0, 1, f2, 8'd200, f2 + (f2 >> 3), "R10");
        repeat (6) drive(1, 0, 32'h0, 8'd0, f2 + (f2 >> 3), "R10");
        // R9: window boundary on both sides
        repeat (2) drive(1, 0, 32'h0, 8'd0, f2 + w2, "R9");
        repeat (2) drive(1, 0, 32'h0, 8'd0, f2 + w2 + 32'd1, "R9");
        repeat (2) drive(1, 0, 32'h0, 8'd0, f2 - w2, "R9");
        repeat (2) drive(1, 0, 32'h0, 8'd0, f2 - w2 - 32'd1, "R9");
        repeat (2) drive(1, 0, 32'h0, 8'd0, f2, "R9");
        // R10: repeat of the same tuning word does not restart blanking
        drive(1, 1, f2, 8'd90, f2 + (f2 >> 4), "R10");
        repeat (3) drive(1, 0, 32'h0, 8'd0, f2 + (f2 >> 4), "R10");
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule